// File: doc/BRIEF.md
# Break/Synch Auto-Baud Detector

This block watches a serial receive line for a calibration preamble. The preamble is a long low break, a high delimiter, and then a 0x55 synch character. The break and the delimiter are timed against the bit period currently in use, which is given as a divisor in reference-clock cycles. The synch character is timed freely, and its length becomes the new divisor. The sender produces the synch pattern simply by transmitting 0x55, whose alternating bits give a falling edge every two bit times.

When a complete preamble is measured, the block presents the new divisor together with a one-cycle load strobe. It also raises a level flag that a receiver can use to gate its ready indication while it sleeps. Two separate error flags report a break that runs too long and a synch field that is too long to measure. Receiving the data bytes that follow the synch field is left to the receiver that sits downstream.

The block has no data stream, so there is no valid/ready handshake. The measured divisor is a held value that is qualified by its strobe, and every other pin is a plain level.

Top module: `autobaud_detect`

## Requirements
- R1: While reset is asserted, and after it is released, the divisor output, the update strobe, both error flags and the preamble flag are all 0.
- R2: A low period counts as a break only if it lasts at least 11 bit times of the current divisor. A shorter low period produces no update, no error and no preamble flag.
- R3: If the line is still low after 22 bit times of break, the break-timeout flag is set, no update follows, and the block waits for the line to go high.
- R4: The 2-bit delimiter code sets the minimum high time between break and synch: code 0 is 1 bit time, 1 is 2, 2 is 3 and 3 is 4. A shorter high time abandons the preamble without an update.
- R5: The synch count runs from the first falling edge of the synch field to the fourth falling edge after it, which is 8 bit times. The new divisor is this cycle count shifted right by 3. It appears on the divisor output, and the update strobe is high for exactly one cycle.
- R6: If the synch counter reaches its all-ones value before the fourth falling edge, the synch-timeout flag is set, the divisor output is left unchanged and no strobe is given.
- R7: While the enable input is 0, nothing is measured, no strobe is given, and all flags are forced to 0.
- R8: The preamble flag is set together with the update strobe and stays set until the next break attempt begins. The start of any new break attempt also clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Detection enable |
| rxd_i | input | 1 | Serial receive line, idle high |
| cur_div_i | input | DIV_W | Current bit period in clock cycles |
| dlm_sel_i | input | 2 | Delimiter length code |
| meas_div_o | output | DIV_W | Last measured bit period |
| div_upd_o | output | 1 | One-cycle strobe when meas_div_o is loaded |
| brk_tmo_o | output | 1 | Break longer than 22 bit times |
| syn_tmo_o | output | 1 | Synch field longer than the counter range |
| bs_ok_o | output | 1 | Complete break and synch preamble seen |

## Verification
The assertions check several properties on every cycle:
- the update strobe lasts one cycle and always comes with the preamble flag and with both error flags clear;
- the divisor output changes only under the strobe and is never loaded with zero;
- a timeout never coincides with an update;
- the two error flags are never set together;
- a low enable silences all outputs.

Whether a break, delimiter or synch field of a given length is accepted, and whether the measured divisor equals the sender's bit period, depends on the whole line waveform. These can only be shown by the bench's scenarios: directed boundary lengths, one case for each delimiter code, a synch field long enough to saturate the counter, and random preambles.

// File: rtl/abd_pkg.sv
package abd_pkg;
  // Break must last at least this many bit times to be accepted.
  localparam int unsigned BRK_MIN_BITS = 11;
  // Break low beyond this many bit times is a timeout.
  localparam int unsigned BRK_MAX_BITS = 22;
  // Width of the bit-time counter used for break and delimiter.
  localparam int unsigned BITS_W = 5;
  // Falling edges that close the synch measurement after the first one.
  localparam int unsigned SYNC_FALLS = 4;
  // Bit times spanned by the synch measurement, as a shift amount.
  localparam int unsigned SYNC_SHIFT = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BRK,
    S_DLM,
    S_SYN,
    S_HOLD
  } abd_state_e;
endpackage

// File: rtl/abd_rx_sync.sv
module abd_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  output logic rx_o,
  output logic fall_o
);
  // STAGES flops of synchronizer plus one flop of history for edge detection.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], rxd_i};
  end

  assign rx_o   = sh[STAGES-1];
  assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/abd_bit_timer.sv
module abd_bit_timer #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned BITS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [BITS_W-1:0] bits_o
);
  logic [DIV_W-1:0]  pre;
  logic [BITS_W-1:0] bits;
  logic              last;

  // A divisor of 0 or 1 makes every cycle one bit time.
  assign last = (div_i <= DIV_W'(1)) || (pre == div_i - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      bits <= '0;
    end else if (clr_i) begin
      pre  <= '0;
      bits <= '0;
    end else if (run_i) begin
      if (last) begin
        pre <= '0;
        if (bits != '1) bits <= bits + BITS_W'(1);
      end else begin
        pre <= pre + DIV_W'(1);
      end
    end
  end

  assign bits_o = bits;
endmodule

// File: rtl/abd_synch_meas.sv
module abd_synch_meas #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SHIFT = 3,
  parameter int unsigned FALLS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             fall_i,
  output logic             done_o,
  output logic             sat_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned CNT_W = DIV_W + SHIFT;
  localparam int unsigned NF_W  = $clog2(FALLS);

  logic [CNT_W-1:0] cnt;
  logic [NF_W-1:0]  nf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      nf  <= '0;
    end else if (start_i) begin
      cnt <= CNT_W'(1);
      nf  <= '0;
    end else if (run_i) begin
      if (!sat_o)  cnt <= cnt + CNT_W'(1);
      if (fall_i)  nf  <= nf + NF_W'(1);
    end
  end

  assign sat_o  = &cnt;
  assign done_o = run_i && fall_i && (nf == NF_W'(FALLS - 1));
  assign div_o  = cnt[CNT_W-1 -: DIV_W];
endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect
  import abd_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] cur_div_i,
  input  logic [1:0]       dlm_sel_i,
  output logic [DIV_W-1:0] meas_div_o,
  output logic             div_upd_o,
  output logic             brk_tmo_o,
  output logic             syn_tmo_o,
  output logic             bs_ok_o
);
  localparam logic [BITS_W-1:0] BRK_MIN_L = BITS_W'(BRK_MIN_BITS);
  localparam logic [BITS_W-1:0] BRK_MAX_L = BITS_W'(BRK_MAX_BITS);

  abd_state_e st, st_n;

  logic              rx, rx_fall;
  logic [BITS_W-1:0] bits;
  logic [BITS_W-1:0] dlm_need;
  logic              tmr_clr, tmr_run;
  logic              m_start, m_run, m_done, m_sat;
  logic [DIV_W-1:0]  m_div;
  logic              ev_begin, ev_ok, ev_btmo, ev_stmo;

  abd_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd_i  (rxd_i),
    .rx_o   (rx),
    .fall_o (rx_fall)
  );

  abd_bit_timer #(.DIV_W(DIV_W), .BITS_W(BITS_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .run_i  (tmr_run),
    .div_i  (cur_div_i),
    .bits_o (bits)
  );

  abd_synch_meas #(.DIV_W(DIV_W), .SHIFT(SYNC_SHIFT), .FALLS(SYNC_FALLS)) u_meas (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (m_start),
    .run_i   (m_run),
    .fall_i  (rx_fall),
    .done_o  (m_done),
    .sat_o   (m_sat),
    .div_o   (m_div)
  );

  // Delimiter code n asks for n+1 bit times of high line.
  assign dlm_need = BITS_W'(dlm_sel_i) + BITS_W'(1);

  always_comb begin
    st_n     = st;
    tmr_clr  = 1'b0;
    tmr_run  = 1'b0;
    m_start  = 1'b0;
    m_run    = 1'b0;
    ev_begin = 1'b0;
    ev_ok    = 1'b0;
    ev_btmo  = 1'b0;
    ev_stmo  = 1'b0;
    if (!en_i) begin
      st_n = S_IDLE;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (!rx) begin
            st_n     = S_BRK;
            tmr_clr  = 1'b1;
            ev_begin = 1'b1;
          end
        end
        S_BRK: begin
          tmr_run = 1'b1;
          if (rx) begin
            if (bits >= BRK_MIN_L) begin
              st_n    = S_DLM;
              tmr_clr = 1'b1;
            end else begin
              st_n = S_IDLE;
            end
          end else if (bits >= BRK_MAX_L) begin
            st_n    = S_HOLD;
            ev_btmo = 1'b1;
          end
        end
        S_DLM: begin
          tmr_run = 1'b1;
          if (!rx) begin
            if (bits >= dlm_need) begin
              st_n    = S_SYN;
              m_start = 1'b1;
            end else begin
              st_n = S_IDLE;
            end
          end
        end
        S_SYN: begin
          m_run = 1'b1;
          if (m_done && !m_sat) begin
            st_n  = S_HOLD;
            ev_ok = 1'b1;
          end else if (m_sat) begin
            st_n    = S_HOLD;
            ev_stmo = 1'b1;
          end
        end
        S_HOLD: begin
          if (rx) st_n = S_IDLE;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      meas_div_o <= '0;
      div_upd_o  <= 1'b0;
      brk_tmo_o  <= 1'b0;
      syn_tmo_o  <= 1'b0;
      bs_ok_o    <= 1'b0;
    end else begin
      st        <= st_n;
      div_upd_o <= ev_ok;
      if (ev_ok) meas_div_o <= m_div;
      if (!en_i || ev_begin) begin
        brk_tmo_o <= 1'b0;
        syn_tmo_o <= 1'b0;
        bs_ok_o   <= 1'b0;
      end else begin
        if (ev_btmo) brk_tmo_o <= 1'b1;
        if (ev_stmo) syn_tmo_o <= 1'b1;
        if (ev_ok)   bs_ok_o   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/autobaud_detect_chk.sv
module autobaud_detect_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic [DIV_W-1:0] meas_div_o,
  input logic             div_upd_o,
  input logic             brk_tmo_o,
  input logic             syn_tmo_o,
  input logic             bs_ok_o
);
  // R5
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_upd_o |=> !div_upd_o);

  // R8
  upd_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_upd_o |-> (bs_ok_o && !brk_tmo_o && !syn_tmo_o));

  // R5
  div_only_on_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_div_o) |-> div_upd_o);

  // R5
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_upd_o |-> (meas_div_o != '0));

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!div_upd_o && !bs_ok_o && !brk_tmo_o && !syn_tmo_o));

  // R6
  stmo_keep_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syn_tmo_o) |-> ($stable(meas_div_o) && !div_upd_o));

  // R3
  btmo_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_tmo_o) |-> !div_upd_o);

  // R3
  tmo_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_tmo_o && syn_tmo_o));
endmodule

bind autobaud_detect autobaud_detect_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .meas_div_o (meas_div_o),
  .div_upd_o  (div_upd_o),
  .brk_tmo_o  (brk_tmo_o),
  .syn_tmo_o  (syn_tmo_o),
  .bs_ok_o    (bs_ok_o)
);

// File: tb/autobaud_detect_bench.sv
module autobaud_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int SAT_CYC    = 1 << (DIV_W + 3);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             rxd = 1'b1;
  logic [DIV_W-1:0] cur_div = '0;
  logic [1:0]       dsel = '0;
  logic [DIV_W-1:0] meas_div;
  logic             div_upd, brk_tmo, syn_tmo, bs_ok;

  int checks = 0;
  int fails = 0;
  int upd_seen = 0;
  int model_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autobaud_detect #(.DIV_W(DIV_W)) u_autobaud_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .rxd_i      (rxd),
    .cur_div_i  (cur_div),
    .dlm_sel_i  (dsel),
    .meas_div_o (meas_div),
    .div_upd_o  (div_upd),
    .brk_tmo_o  (brk_tmo),
    .syn_tmo_o  (syn_tmo),
    .bs_ok_o    (bs_ok)
  );

  always @(negedge clk) if (rst_n && div_upd) upd_seen++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // 0 = no result, 1 = accepted preamble, 2 = break timeout
  function automatic int exp_kind(input int brk_bits, input bit dlm_ok, input bit en_v);
    if (!en_v) return 0;
    if (brk_bits >= 23) return 2;
    if (brk_bits < 11) return 0;
    if (!dlm_ok) return 0;
    return 1;
  endfunction

  function automatic string kind_tag(input int brk_bits, input bit dlm_ok, input bit en_v);
    if (!en_v) return "R7";
    if (brk_bits >= 23) return "R3";
    if (brk_bits < 11) return "R2";
    if (!dlm_ok) return "R4";
    return "R5";
  endfunction

  task automatic send_seq(input int cd, input int brk_bits, input int ds,
                          input bit dlm_ok, input int b, input bit en_v);
    logic [7:0] pat;
    int h, k;
    string tg;
    pat = 8'h55;
    @(negedge clk);
    cur_div = DIV_W'(cd);
    dsel = 2'(ds);
    en = en_v;
    upd_seen = 0;
    line(1'b1, 20);
    line(1'b0, brk_bits * cd);
    if (brk_bits < 23) begin
      if (dlm_ok) h = (ds + 2) * cd;
      else if (ds == 0) h = cd / 2;
      else h = ds * cd;
      line(1'b1, h);
      line(1'b0, b);
      for (int i = 0; i < 8; i++) line(pat[i], b);
      line(1'b1, b);
    end
    line(1'b1, 40);
    k = exp_kind(brk_bits, dlm_ok, en_v);
    tg = kind_tag(brk_bits, dlm_ok, en_v);
    if (k == 1) model_div = b;
    chk({tg, " strobe count"}, upd_seen, (k == 1) ? 1 : 0);
    chk({tg, " divisor"}, int'(meas_div), model_div);
    chk({tg, " break timeout"}, int'(brk_tmo), (k == 2) ? 1 : 0);
    chk({tg, " synch timeout"}, int'(syn_tmo), 0);
    chk({tg, " R8 preamble flag"}, int'(bs_ok), (k == 1) ? 1 : 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int cd, b, ds, r, bb;
    bit dok, env;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    chk("R1 div in reset", int'(meas_div), 0);
    chk("R1 flags in reset", int'({div_upd, brk_tmo, syn_tmo, bs_ok}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 flags after reset", int'({div_upd, brk_tmo, syn_tmo, bs_ok}), 0);
    en = 1'b1;

    // Directed: break length boundaries
    send_seq(8, 12, 0, 1'b1, 16, 1'b1);   // R5 accepted
    send_seq(8, 10, 0, 1'b1, 20, 1'b1);   // R2 too short
    send_seq(6, 26, 1, 1'b1, 10, 1'b1);   // R3 timeout
    send_seq(6, 20, 1, 1'b1, 33, 1'b1);   // R5 long valid break
    // R4: every delimiter code, long enough and too short
    for (int d = 0; d < 4; d++) begin
      send_seq(5, 14, d, 1'b1, 7 + d, 1'b1);
      send_seq(5, 14, d, 1'b0, 30, 1'b1);
    end
    // R7: disabled, full valid preamble ignored
    send_seq(7, 14, 2, 1'b1, 25, 1'b0);

    // R8: flag held, then cleared by a new break attempt
    send_seq(4, 15, 0, 1'b1, 12, 1'b1);
    line(1'b1, 30);
    chk("R8 flag held while idle", int'(bs_ok), 1);
    line(1'b0, 12);
    line(1'b1, 20);
    chk("R8 flag cleared by new break", int'(bs_ok), 0);

    // R7: dropping enable clears the flag
    send_seq(4, 15, 0, 1'b1, 9, 1'b1);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 flag cleared by disable", int'(bs_ok), 0);
    en = 1'b1;

    // R6: synch field too long for the counter
    @(negedge clk);
    cur_div = DIV_W'(6);
    dsel = 2'd1;
    upd_seen = 0;
    line(1'b1, 20);
    line(1'b0, 14 * 6);
    line(1'b1, 3 * 6);
    line(1'b0, 10);
    line(1'b1, SAT_CYC + 200);
    chk("R6 synch timeout", int'(syn_tmo), 1);
    chk("R6 no strobe", upd_seen, 0);
    chk("R6 divisor kept", int'(meas_div), model_div);
    chk("R6 no preamble flag", int'(bs_ok), 0);

    // Random preambles
    for (int n = 0; n < 30; n++) begin
      cd = 4 + int'($urandom % 9);
      b  = 4 + int'($urandom % 37);
      ds = int'($urandom % 4);
      r  = int'($urandom % 10);
      if (r < 2) bb = 8 + int'($urandom % 3);
      else if (r == 2) bb = ($urandom % 2) ? 24 : 26;
      else bb = 12 + int'($urandom % 9);
      dok = ($urandom % 5) != 0;
      env = ($urandom % 8) != 0;
      send_seq(cd, bb, ds, dok, b, env);
    end
    en = 1'b1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule